// File: doc/BRIEF.md
# Trap Return Privilege Restore Unit

This block carries out the three trap-return instructions of a 32-bit RISC-V style core: the user-level, supervisor-level and machine-level returns. A 32-bit instruction word arrives with a valid flag. When the word is one of the three returns, the unit reads the current status word and the stored privilege level from the CSR file. It computes the restored privilege level and the new status word. It then drives write strobes back to the CSR file and a redirect PC taken from the exception-PC register that belongs to the returning level.

The status word has three views (user, supervisor and machine). Every return writes the same updated value into all three views at once. The privilege register is written only when the restored level differs from the stored one. That same condition raises a one-cycle context-switch strobe toward the external memory-management unit, so address translation state can be refreshed. Words that are not a trap return cause no writes, no redirect and no strobe. Illegal-instruction checks, interrupt delivery and trap entry are handled elsewhere.

All outputs are registered. They appear one clock after the accepted word, as single-cycle pulses.

Top module: `trap_ret_unit`

## Requirements
- R1: A word is a return only if all of these fields match: bits [6:0] = 1110011, bits [11:7] = 0, bits [14:12] = 0, bits [19:15] = 0 and bits [24:20] = 00010. Bits [31:25] then select the kind: 0000000 is a user return (0x00200073), 0001000 is a supervisor return (0x10200073) and 0011000 is a machine return (0x30200073).
- R2: When `ins_valid` is low, or when the word does not match R1, the following cycle shows no redirect, no status or privilege write enable and no context-switch strobe.
- R3: The outputs for an accepted return appear in the cycle after the clock edge that samples it, and last exactly one cycle. Returns issued on consecutive cycles each get their own output cycle.
- R4: Machine return:
  - The new privilege is status bits [12:11].
  - The written status clears bits [12:11], and its bit 3 takes the old bit 7.
  - The redirect PC is `epc_mach`.
- R5: Supervisor return:
  - The new privilege is {0, status bit 8}.
  - The written status clears bit 8, and its bit 1 takes the old bit 5.
  - The redirect PC is `epc_super`.
- R6: User return:
  - The new privilege is 0.
  - The written status has bit 0 set to the old bit 4.
  - The redirect PC is `epc_user`.
- R7: On every return, `ustat_we`, `sstat_we` and `mstat_we` are all high together, with one shared `stat_wdata`.
- R8: `priv_we` and `ctx_switch` are high only when the new privilege differs from `priv_rdata`. `priv_wdata` carries the new privilege (0 = user, 1 = supervisor, 3 = machine).
- R9: The previous-interrupt-enable bits (7, 5 and 4) keep their old values after any return. All bits not named in R4 to R6 also keep their old values.
- R10: While reset is active, and in the first cycle after it, every valid, write-enable and strobe output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction word is presented this cycle |
| ins_word | input | 32 | Instruction word |
| stat_rdata | input | 32 | Current status word from the CSR file |
| priv_rdata | input | 2 | Current privilege level from the CSR file |
| epc_user | input | 32 | User exception PC |
| epc_super | input | 32 | Supervisor exception PC |
| epc_mach | input | 32 | Machine exception PC |
| redir_valid | output | 1 | Redirect pulse |
| redir_pc | output | 32 | Redirect target |
| ustat_we | output | 1 | Write enable, user status view |
| sstat_we | output | 1 | Write enable, supervisor status view |
| mstat_we | output | 1 | Write enable, machine status view |
| stat_wdata | output | 32 | New status value for all views |
| priv_we | output | 1 | Privilege register write enable |
| priv_wdata | output | 2 | New privilege level |
| ctx_switch | output | 1 | Context-switch strobe toward the MMU |

## Verification
Two functions can land in the same output cycle: the three-view status write together with the redirect, and the context-switch strobe with its privilege write. The bench triggers them by pairing each return kind with a stored privilege that is equal to the restored level in one case and different in another. It checks that the strobe fires only in the differing case, while the status write and redirect fire in both. Two returns issued on consecutive cycles confirm that each output cycle carries its own status value, PC and strobe decision without smearing into the next.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;

   typedef enum logic [1:0] {
      RET_NONE  = 2'd0,
      RET_USER  = 2'd1,
      RET_SUPER = 2'd2,
      RET_MACH  = 2'd3
   } ret_kind_e;

   localparam int unsigned N_KINDS = 3;

   // fixed fields of a return word
   localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
   localparam logic [4:0] RS2_RETSEL = 5'b00010;

   // status word bit positions (decoded by neighbouring CSR logic)
   localparam int unsigned ST_UIE     = 0;
   localparam int unsigned ST_SIE     = 1;
   localparam int unsigned ST_MIE     = 3;
   localparam int unsigned ST_UPIE    = 4;
   localparam int unsigned ST_SPIE    = 5;
   localparam int unsigned ST_MPIE    = 7;
   localparam int unsigned ST_SPP     = 8;
   localparam int unsigned ST_MPP_LO  = 11;
   localparam int unsigned ST_MPP_HI  = 12;
   localparam int unsigned ST_MIN_W   = ST_MPP_HI + 1;

   localparam logic [1:0] PRIV_USER  = 2'd0;
   localparam logic [1:0] PRIV_MACH  = 2'd3;

   // upper-field code per kind index (0 user, 1 super, 2 machine)
   function automatic logic [6:0] kind_code(input int unsigned idx);
      case (idx)
         0:       kind_code = 7'b0000000;
         1:       kind_code = 7'b0001000;
         default: kind_code = 7'b0011000;
      endcase
   endfunction

endpackage

// File: rtl/trap_ret_decode.sv
module trap_ret_decode
   import trap_ret_pkg::*;
#(
   parameter int unsigned ILEN = 32
) (
   input  logic            valid,
   input  logic [ILEN-1:0] word,
   output ret_kind_e       kind
);

   if (ILEN != 32) begin : g_ilen_bad
      $error("trap_ret_decode: ILEN must be 32");
   end

   logic             base_ok;
   logic [N_KINDS-1:0] hit;

   // R1 fixed fields
   assign base_ok = valid
                 && (word[6:0]   == OPC_SYSTEM)
                 && (word[11:7]  == 5'd0)
                 && (word[14:12] == 3'd0)
                 && (word[19:15] == 5'd0)
                 && (word[24:20] == RS2_RETSEL);

   for (genvar gi = 0; gi < N_KINDS; gi++) begin : g_kind
      assign hit[gi] = base_ok && (word[31:25] == kind_code(gi));
   end

   always_comb begin
      kind = RET_NONE;
      if (hit[2])      kind = RET_MACH;
      else if (hit[1]) kind = RET_SUPER;
      else if (hit[0]) kind = RET_USER;
   end

endmodule

// File: rtl/trap_ret_status.sv
module trap_ret_status
   import trap_ret_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  ret_kind_e        kind,
   input  logic [XLEN-1:0]  stat_in,
   output logic [XLEN-1:0]  stat_out,
   output logic [1:0]       new_priv
);

   if (XLEN < ST_MIN_W) begin : g_xlen_bad
      $error("trap_ret_status: XLEN too narrow for status fields");
   end

   always_comb begin
      stat_out = stat_in;
      new_priv = PRIV_USER;
      case (kind)
         RET_MACH: begin
            new_priv                      = stat_in[ST_MPP_HI:ST_MPP_LO];
            stat_out[ST_MPP_HI:ST_MPP_LO] = 2'b00;
            stat_out[ST_MIE]              = stat_in[ST_MPIE];
         end
         RET_SUPER: begin
            new_priv          = {1'b0, stat_in[ST_SPP]};
            stat_out[ST_SPP]  = 1'b0;
            stat_out[ST_SIE]  = stat_in[ST_SPIE];
         end
         RET_USER: begin
            new_priv          = PRIV_USER;
            stat_out[ST_UIE]  = stat_in[ST_UPIE];
         end
         default: begin
            new_priv = PRIV_USER;
         end
      endcase
   end

endmodule

// File: rtl/trap_ret_unit.sv
module trap_ret_unit
   import trap_ret_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned ILEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ins_valid,
   input  logic [ILEN-1:0] ins_word,
   input  logic [XLEN-1:0] stat_rdata,
   input  logic [1:0]      priv_rdata,
   input  logic [XLEN-1:0] epc_user,
   input  logic [XLEN-1:0] epc_super,
   input  logic [XLEN-1:0] epc_mach,
   output logic            redir_valid,
   output logic [XLEN-1:0] redir_pc,
   output logic            ustat_we,
   output logic            sstat_we,
   output logic            mstat_we,
   output logic [XLEN-1:0] stat_wdata,
   output logic            priv_we,
   output logic [1:0]      priv_wdata,
   output logic            ctx_switch
);

   localparam int unsigned N_VIEWS = 3;

   ret_kind_e       kind;
   logic [XLEN-1:0] stat_nxt;
   logic [1:0]      priv_nxt;
   logic [XLEN-1:0] pc_nxt;
   logic            is_ret;
   logic            priv_diff;

   trap_ret_decode #(.ILEN(ILEN)) i_decode (
      .valid (ins_valid),
      .word  (ins_word),
      .kind  (kind)
   );

   trap_ret_status #(.XLEN(XLEN)) i_status (
      .kind     (kind),
      .stat_in  (stat_rdata),
      .stat_out (stat_nxt),
      .new_priv (priv_nxt)
   );

   assign is_ret    = (kind != RET_NONE);
   assign priv_diff = is_ret && (priv_nxt != priv_rdata);

   always_comb begin
      case (kind)
         RET_MACH:  pc_nxt = epc_mach;
         RET_SUPER: pc_nxt = epc_super;
         default:   pc_nxt = epc_user;
      endcase
   end

   // data path registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redir_valid <= 1'b0;
         redir_pc    <= '0;
         stat_wdata  <= '0;
         priv_we     <= 1'b0;
         priv_wdata  <= PRIV_MACH;
         ctx_switch  <= 1'b0;
      end else begin
         redir_valid <= is_ret;
         priv_we     <= priv_diff;
         ctx_switch  <= priv_diff;
         if (is_ret) begin
            redir_pc   <= pc_nxt;
            stat_wdata <= stat_nxt;
            priv_wdata <= priv_nxt;
         end
      end
   end

   // one write-enable flop per status view
   logic [N_VIEWS-1:0] view_we_q;
   for (genvar gv = 0; gv < N_VIEWS; gv++) begin : g_view
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) view_we_q[gv] <= 1'b0;
         else        view_we_q[gv] <= is_ret;
      end
   end

   assign ustat_we = view_we_q[0];
   assign sstat_we = view_we_q[1];
   assign mstat_we = view_we_q[2];

   // R2
   nomatch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == RET_NONE) |=> !(redir_valid || priv_we || ctx_switch
                               || ustat_we || sstat_we || mstat_we));

   // R3
   pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> $past(ins_valid));

   // R7
   views_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (ustat_we && sstat_we && mstat_we));

   // R8
   ctx_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_switch |-> (redir_valid && priv_we && (priv_wdata != $past(priv_rdata))));

   // R8
   ctx_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_valid && (priv_wdata == $past(priv_rdata))) |-> !ctx_switch);

   // R4
   mach_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(kind) == RET_MACH && redir_valid) |->
         (stat_wdata[ST_MPP_HI:ST_MPP_LO] == 2'b00
          && stat_wdata[ST_MIE] == $past(stat_rdata[ST_MPIE])));

   // R9
   pie_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (stat_wdata[ST_MPIE] == $past(stat_rdata[ST_MPIE])
                       && stat_wdata[ST_SPIE] == $past(stat_rdata[ST_SPIE])
                       && stat_wdata[ST_UPIE] == $past(stat_rdata[ST_UPIE])));

endmodule

// File: tb/test_trap_ret_unit.sv
module test_trap_ret_unit;

   localparam logic [31:0] W_URET = 32'h0020_0073;
   localparam logic [31:0] W_SRET = 32'h1020_0073;
   localparam logic [31:0] W_MRET = 32'h3020_0073;
   localparam logic [31:0] PC_U   = 32'h1000_0040;
   localparam logic [31:0] PC_S   = 32'h2000_0080;
   localparam logic [31:0] PC_M   = 32'h3000_00C0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ins_valid = 1'b0;
   logic [31:0] ins_word = '0;
   logic [31:0] stat_rdata = '0;
   logic [1:0]  priv_rdata = 2'd3;
   logic        redir_valid, ustat_we, sstat_we, mstat_we, priv_we, ctx_switch;
   logic [31:0] redir_pc, stat_wdata;
   logic [1:0]  priv_wdata;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   trap_ret_unit i_trap_ret_unit (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
      .stat_rdata(stat_rdata), .priv_rdata(priv_rdata),
      .epc_user(PC_U), .epc_super(PC_S), .epc_mach(PC_M),
      .redir_valid(redir_valid), .redir_pc(redir_pc),
      .ustat_we(ustat_we), .sstat_we(sstat_we), .mstat_we(mstat_we),
      .stat_wdata(stat_wdata), .priv_we(priv_we), .priv_wdata(priv_wdata),
      .ctx_switch(ctx_switch)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // kind: 1 user, 2 super, 3 machine
   function automatic logic [31:0] exp_stat(input int k, input logic [31:0] s);
      logic [31:0] r;
      r = s;
      if (k == 3) begin r[12:11] = 2'b00; r[3] = s[7]; end
      else if (k == 2) begin r[8] = 1'b0; r[1] = s[5]; end
      else r[0] = s[4];
      return r;
   endfunction

   function automatic logic [1:0] exp_priv(input int k, input logic [31:0] s);
      if (k == 3) return s[12:11];
      if (k == 2) return {1'b0, s[8]};
      return 2'd0;
   endfunction

   function automatic logic [31:0] word_of(input int k);
      if (k == 3) return W_MRET;
      if (k == 2) return W_SRET;
      return W_URET;
   endfunction

   function automatic logic [31:0] pc_of(input int k);
      if (k == 3) return PC_M;
      if (k == 2) return PC_S;
      return PC_U;
   endfunction

   task automatic check_outputs(input int k, input logic [31:0] s, input logic [1:0] p);
      logic [1:0] np;
      logic chg;
      np  = exp_priv(k, s);
      chg = (np != p);
      check("R3 redir_valid", {31'd0, redir_valid}, 32'd1);
      check("R4/R5/R6 redir_pc", redir_pc, pc_of(k));
      check("R4/R5/R6/R9 stat_wdata", stat_wdata, exp_stat(k, s));
      check("R7 view write enables", {29'd0, ustat_we, sstat_we, mstat_we}, 32'd7);
      check("R8 priv_we", {31'd0, priv_we}, {31'd0, chg});
      check("R8 ctx_switch", {31'd0, ctx_switch}, {31'd0, chg});
      if (chg) check("R8 priv_wdata", {30'd0, priv_wdata}, {30'd0, np});
   endtask

   task automatic check_quiet(input string tag);
      check(tag, {26'd0, redir_valid, ustat_we, sstat_we, mstat_we, priv_we, ctx_switch}, 32'd0);
   endtask

   // one return, then confirm single-cycle pulse
   task automatic t_single(input int k, input logic [31:0] s, input logic [1:0] p);
      @(negedge clk);
      ins_valid = 1'b1; ins_word = word_of(k); stat_rdata = s; priv_rdata = p;
      @(negedge clk);
      ins_valid = 1'b0; ins_word = '0;
      check_outputs(k, s, p);
      @(negedge clk);
      check_quiet("R3 pulse ends after one cycle");
   endtask

   task automatic t_nomatch(input logic v, input logic [31:0] w, input string tag);
      @(negedge clk);
      ins_valid = v; ins_word = w; stat_rdata = 32'hFFFF_FFFF; priv_rdata = 2'd0;
      @(negedge clk);
      ins_valid = 1'b0; ins_word = '0;
      check_quiet(tag);
   endtask

   // machine return then supervisor return on consecutive cycles
   task automatic t_back_to_back();
      @(negedge clk);
      ins_valid = 1'b1; ins_word = W_MRET; stat_rdata = 32'h0000_0888; priv_rdata = 2'd3;
      @(negedge clk);
      check_outputs(3, 32'h0000_0888, 2'd3);
      ins_word = W_SRET; stat_rdata = 32'h0000_0020; priv_rdata = 2'd1;
      @(negedge clk);
      ins_valid = 1'b0; ins_word = '0;
      check_outputs(2, 32'h0000_0020, 2'd1);
      @(negedge clk);
      check_quiet("R3 back-to-back ends");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_quiet("R10 outputs during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_quiet("R10 outputs after reset");

      // R4 machine: same level, to supervisor, all-ones from user
      t_single(3, 32'h0000_1888, 2'd3);
      t_single(3, 32'h0000_0808, 2'd3);
      t_single(3, 32'hFFFF_FFFF, 2'd0);
      // R5 supervisor
      t_single(2, 32'h0000_0120, 2'd1);
      t_single(2, 32'h0000_0002, 2'd3);
      t_single(2, 32'hFFFF_FEDF, 2'd0);
      // R6 user
      t_single(1, 32'h0000_0010, 2'd0);
      t_single(1, 32'h0000_0001, 2'd1);
      // R9 interrupt-enable history bits kept when clear
      t_single(3, 32'h0000_1000, 2'd3);

      // R1/R2 non-matching words
      t_nomatch(1'b0, W_MRET,       "R2 valid low");
      t_nomatch(1'b1, 32'h3020_8073, "R1 rs1 nonzero");
      t_nomatch(1'b1, 32'h3020_00F3, "R1 rd nonzero");
      t_nomatch(1'b1, 32'h3020_1073, "R1 funct3 nonzero");
      t_nomatch(1'b1, 32'h3030_0073, "R1 rs2 wrong");
      t_nomatch(1'b1, 32'h3020_0033, "R1 opcode wrong");
      t_nomatch(1'b1, 32'h7020_0073, "R1 upper field wrong");

      t_back_to_back();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule